// File: doc/BRIEF.md
# Asynchronous Static RAM Controller with Programmable Phase Timing

This controller connects a simple valid/ready request port inside the chip to an external asynchronous static RAM with a 16-bit data bus. Each request is a read or a write of either one halfword or one 32-bit word. A 32-bit request is carried out as two halfword beats on the memory side. The controller produces chip select, output enable, write enable, two byte-lane strobes, the address and a tri-state data bus. The timing of every phase comes from a small set of configuration registers.

Every phase of an access has its own programmed count, and each count has its own fixed offset. The settings are: the delay from chip select to output enable, the read beat length, the length of a page-mode follow-on read, the delay from chip select to write enable, the write beat length, and the idle gap that separates accesses. A control register selects three options: the chip-select polarity, whether the byte lanes also assert on reads, and whether a 32-bit read uses page mode. Configuration writes go into staging registers. The controller copies them when it accepts a request, so a write made during an access has no effect on that access and applies from the next request onward.

Top module: `sram_timing_ctrl`

## Requirements
- R1: After reset the controller is idle. Chip select is at its inactive level (high, because the polarity resets to active low). `mem_oe_n`, `mem_we_n` and both `mem_bls_n` bits are high, `mem_dq` is released, and `req_ready` is high.
- R2: A read beat keeps chip select active for rd_len+1 cycles. Output enable first asserts oe_dly cycles after chip select asserts, with no offset. The read data is sampled in the last cycle of the beat.
- R3: A write beat keeps chip select active for wr_len+2 cycles. Write enable is asserted from beat cycle we_dly+1 up to and including beat cycle wr_len, which is wr_len-we_dly cycles. Write enable stays high if that count is not positive.
- R4: The controller drives `mem_dq` only during a write beat and releases it at all other times. Output enable and write enable are never active together, and neither is active outside chip select.
- R5: The byte-lane strobes are active low. `mem_bls_n[0]` covers data bits 7:0 and `mem_bls_n[1]` covers bits 15:8. During a write, a lane asserts together with write enable only when its request byte enable is set.
- R6: Control bit 1 set means both lanes stay low for the whole of a read. Control bit 1 clear means the lanes stay high during reads.
- R7: A 32-bit request (`req_wide`=1) makes two beats. The first beat uses the even halfword address (`req_addr` with bit 0 cleared) and carries bits 15:0. The second beat uses the odd address and carries bits 31:16. For a read, both halves are collected before the single response, with bits 15:0 from the first beat.
- R8: Chip select is inactive for exactly turn+1 cycles between the two beats of a 32-bit request (when page mode is not used). It is inactive for at least turn+1 cycles between two requests.
- R9: When control bit 2 is set, the second beat of a 32-bit read follows the first without releasing chip select or output enable, and it lasts pg_len+1 cycles. This setting has no effect on writes.
- R10: Control bit 0 set makes chip select active high. Control bit 0 clear makes it active low.
- R11: `cfg_sel` chooses the register: 0 oe_dly (4 bits), 1 rd_len (5 bits), 2 pg_len (5 bits), 3 we_dly (4 bits), 4 wr_len (5 bits), 5 turn (4 bits), 6 control (3 bits). A request uses the values held when it was accepted. A write made during an access affects only the next request.
- R12: `req_ready` is high only while the controller is idle. Each request produces exactly one single-cycle `rsp_valid` pulse. A halfword read returns zeros in bits 31:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_sel | input | 3 | Configuration register index |
| cfg_wdata | input | 5 | Configuration write value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller accepts a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 32-bit request, 0 = halfword |
| req_addr | input | AW (19) | Halfword address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for the write data |
| rsp_valid | output | 1 | Request complete (one-cycle pulse) |
| rsp_rdata | output | 32 | Read data |
| mem_cs | output | 1 | Chip select, polarity set by configuration |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bls_n | output | 2 | Byte-lane strobes, active low |
| mem_addr | output | AW (19) | Memory halfword address |
| mem_dq | inout | 16 | Bidirectional data bus |

## Verification
A wrong phase counter or a wrong offset shows up in the very next access as a chip-select, output-enable or write-enable window that is one or more cycles too long or too short. The bench sweeps the small count ranges and measures these windows cycle by cycle. A beat sequencing error shows within the same request: the second halfword lands at the wrong address, the two halves of a read are assembled in the wrong order, or the gap between beats has the wrong length. A configuration register that is not isolated from an access in progress changes the length of that access, which the bench detects by rewriting a count in the middle of a read.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    localparam int SHORT_W = 4;
    localparam int LONG_W  = 5;
    localparam int CNT_W   = LONG_W + 1;
    localparam int CFG_W   = LONG_W;
    localparam int SEL_W   = 3;

    localparam logic [SEL_W-1:0] SEL_OE   = 3'd0;
    localparam logic [SEL_W-1:0] SEL_RD   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_PG   = 3'd2;
    localparam logic [SEL_W-1:0] SEL_WE   = 3'd3;
    localparam logic [SEL_W-1:0] SEL_WR   = 3'd4;
    localparam logic [SEL_W-1:0] SEL_TURN = 3'd5;
    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd6;

    typedef struct packed {
        logic [SHORT_W-1:0] oe_dly;
        logic [LONG_W-1:0]  rd_len;
        logic [LONG_W-1:0]  pg_len;
        logic [SHORT_W-1:0] we_dly;
        logic [LONG_W-1:0]  wr_len;
        logic [SHORT_W-1:0] turn;
        logic               cs_high;
        logic               lanes_rd;
        logic               page_en;
    } timing_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD,
        PH_PG,
        PH_WR,
        PH_TURN
    } phase_e;

endpackage

// File: rtl/sram_cfg_regs.sv
module sram_cfg_regs
    import sram_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output timing_t          stage
);

    timing_t stage_d, stage_q;

    always_comb begin
        stage_d = stage_q;
        if (cfg_wr) begin
            case (cfg_sel)
                SEL_OE:   stage_d.oe_dly = cfg_wdata[SHORT_W-1:0];
                SEL_RD:   stage_d.rd_len = cfg_wdata[LONG_W-1:0];
                SEL_PG:   stage_d.pg_len = cfg_wdata[LONG_W-1:0];
                SEL_WE:   stage_d.we_dly = cfg_wdata[SHORT_W-1:0];
                SEL_WR:   stage_d.wr_len = cfg_wdata[LONG_W-1:0];
                SEL_TURN: stage_d.turn   = cfg_wdata[SHORT_W-1:0];
                SEL_CTRL: begin
                    stage_d.cs_high  = cfg_wdata[0];
                    stage_d.lanes_rd = cfg_wdata[1];
                    stage_d.page_en  = cfg_wdata[2];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign stage = stage_q;

    // R11: staging registers change only on a configuration write
    p_stage_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(stage_q));

endmodule

// File: rtl/sram_phase_fsm.sv
module sram_phase_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int AW = 19,
    parameter int DW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  timing_t               stage,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic                  req_wide,
    input  logic [AW-1:0]         req_addr,
    input  logic [2*DW-1:0]       req_wdata,
    input  logic [2*DW/8-1:0]     req_be,
    input  logic [DW-1:0]         dq_in,
    output logic                  req_ready,
    output logic                  rsp_valid,
    output logic [2*DW-1:0]       rsp_rdata,
    output phase_e                phase,
    output logic [CNT_W-1:0]      cnt,
    output timing_t               act,
    output logic [AW-1:0]         addr,
    output logic [DW-1:0]         beat_wdata,
    output logic [DW/8-1:0]       beat_be
);

    localparam int LANES = DW / 8;

    typedef struct packed {
        phase_e               phase;
        logic [CNT_W-1:0]     cnt;
        logic                 beat;
        logic                 wide;
        logic                 write;
        logic                 pending;
        logic [AW-1:0]        addr;
        logic [2*DW-1:0]      wdata;
        logic [2*LANES-1:0]   be;
        logic [2*DW-1:0]      rdata;
        logic                 rsp;
        timing_t              act;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        seq_d.rsp = 1'b0;
        case (seq_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    seq_d.act     = stage;
                    seq_d.write   = req_write;
                    seq_d.wide    = req_wide;
                    seq_d.wdata   = req_wdata;
                    seq_d.be      = req_be;
                    seq_d.addr    = req_wide ? {req_addr[AW-1:1], 1'b0} : req_addr;
                    seq_d.beat    = 1'b0;
                    seq_d.pending = 1'b0;
                    seq_d.cnt     = '0;
                    seq_d.rdata   = '0;
                    seq_d.phase   = req_write ? PH_WR : PH_RD;
                end
            end
            PH_RD: begin
                if (seq_q.cnt == {1'b0, seq_q.act.rd_len}) begin
                    seq_d.cnt = '0;
                    if (seq_q.beat) seq_d.rdata[2*DW-1:DW] = dq_in;
                    else            seq_d.rdata[DW-1:0]    = dq_in;
                    if (seq_q.wide && !seq_q.beat) begin
                        seq_d.beat    = 1'b1;
                        seq_d.addr    = {seq_q.addr[AW-1:1], 1'b1};
                        seq_d.pending = !seq_q.act.page_en;
                        seq_d.phase   = seq_q.act.page_en ? PH_PG : PH_TURN;
                    end else begin
                        seq_d.rsp   = 1'b1;
                        seq_d.phase = PH_TURN;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            PH_PG: begin
                if (seq_q.cnt == {1'b0, seq_q.act.pg_len}) begin
                    seq_d.cnt                 = '0;
                    seq_d.rdata[2*DW-1:DW]    = dq_in;
                    seq_d.rsp                 = 1'b1;
                    seq_d.phase               = PH_TURN;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            PH_WR: begin
                if (seq_q.cnt == {1'b0, seq_q.act.wr_len} + 1'b1) begin
                    seq_d.cnt   = '0;
                    seq_d.phase = PH_TURN;
                    if (seq_q.wide && !seq_q.beat) begin
                        seq_d.beat    = 1'b1;
                        seq_d.addr    = {seq_q.addr[AW-1:1], 1'b1};
                        seq_d.pending = 1'b1;
                    end else begin
                        seq_d.rsp = 1'b1;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            PH_TURN: begin
                if (seq_q.cnt == CNT_W'(seq_q.act.turn)) begin
                    seq_d.cnt = '0;
                    if (seq_q.pending) begin
                        seq_d.pending = 1'b0;
                        seq_d.phase   = seq_q.write ? PH_WR : PH_RD;
                    end else begin
                        seq_d.phase = PH_IDLE;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign req_ready  = (seq_q.phase == PH_IDLE);
    assign rsp_valid  = seq_q.rsp;
    assign rsp_rdata  = seq_q.rdata;
    assign phase      = seq_q.phase;
    assign cnt        = seq_q.cnt;
    assign act        = seq_q.act;
    assign addr       = seq_q.addr;
    assign beat_wdata = seq_q.beat ? seq_q.wdata[2*DW-1:DW] : seq_q.wdata[DW-1:0];
    assign beat_be    = seq_q.beat ? seq_q.be[2*LANES-1:LANES] : seq_q.be[LANES-1:0];

    // R12: completion is a single-cycle pulse
    p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.rsp |=> !seq_q.rsp);

    // R11: latched timing is frozen while an access is in progress
    p_act_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase != PH_IDLE) |=> $stable(seq_q.act));

    // R7: a 32-bit request uses the even address first, the odd one second
    p_pair_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.phase == PH_RD || seq_q.phase == PH_WR) && seq_q.wide)
            |-> (seq_q.addr[0] == seq_q.beat));

    // R2: address steady inside a read beat, count within the programmed length
    p_rd_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_RD && seq_q.cnt != '0)
            |-> ($stable(seq_q.addr) && seq_q.cnt <= {1'b0, seq_q.act.rd_len}));

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
    import sram_ctrl_pkg::*;
#(
    parameter int AW = 19,
    parameter int DW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  phase_e             phase,
    input  logic [CNT_W-1:0]   cnt,
    input  logic [SHORT_W-1:0] oe_dly,
    input  logic [SHORT_W-1:0] we_dly,
    input  logic [LONG_W-1:0]  wr_len,
    input  logic               cs_high,
    input  logic               lanes_rd,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      beat_wdata,
    input  logic [DW/8-1:0]    beat_be,
    output logic               mem_cs,
    output logic               mem_oe_n,
    output logic               mem_we_n,
    output logic [DW/8-1:0]    mem_bls_n,
    output logic [AW-1:0]      mem_addr,
    output logic [DW-1:0]      dq_out,
    output logic               dq_oe
);

    localparam int LANES = DW / 8;

    logic cs_act, rd_act, oe_act, we_act;

    always_comb begin
        rd_act = (phase == PH_RD) || (phase == PH_PG);
        cs_act = rd_act || (phase == PH_WR);
        oe_act = ((phase == PH_RD) && (cnt >= CNT_W'(oe_dly))) || (phase == PH_PG);
        we_act = (phase == PH_WR)
              && (cnt >= CNT_W'(we_dly) + 1'b1)
              && (cnt <= {1'b0, wr_len});
    end

    always_comb begin
        mem_bls_n = '1;
        if (we_act)                  mem_bls_n = ~beat_be;
        else if (rd_act && lanes_rd) mem_bls_n = '0;
    end

    assign mem_cs   = cs_high ? cs_act : !cs_act;
    assign mem_oe_n = !oe_act;
    assign mem_we_n = !we_act;
    assign mem_addr = addr;
    assign dq_out   = beat_wdata;
    assign dq_oe    = (phase == PH_WR);

    // R4: strobes never overlap and stay inside chip select
    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_oe_n == 1'b0 && mem_we_n == 1'b0)
        && ((mem_oe_n && mem_we_n) || cs_act));

    // R4: bus driven only while output enable is off and chip select is on
    p_bus_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (cs_act && mem_oe_n));

    // R5: a write lane only asserts together with write enable
    p_lane_qual_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && (mem_bls_n != {LANES{1'b1}})) |-> !mem_we_n);

endmodule

// File: rtl/sram_timing_ctrl.sv
module sram_timing_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW = 19,
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [2:0]           cfg_sel,
    input  logic [4:0]           cfg_wdata,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic                 req_wide,
    input  logic [AW-1:0]        req_addr,
    input  logic [2*DW-1:0]      req_wdata,
    input  logic [2*DW/8-1:0]    req_be,
    output logic                 rsp_valid,
    output logic [2*DW-1:0]      rsp_rdata,
    output logic                 mem_cs,
    output logic                 mem_oe_n,
    output logic                 mem_we_n,
    output logic [DW/8-1:0]      mem_bls_n,
    output logic [AW-1:0]        mem_addr,
    inout  wire  [DW-1:0]        mem_dq
);

    localparam int LANES = DW / 8;

    timing_t          stage, act;
    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic [AW-1:0]    addr;
    logic [DW-1:0]    beat_wdata, dq_out;
    logic [LANES-1:0] beat_be;
    logic             dq_oe;

    sram_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .stage     (stage)
    );

    sram_phase_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .stage      (stage),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_wide   (req_wide),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_be     (req_be),
        .dq_in      (mem_dq),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .phase      (phase),
        .cnt        (cnt),
        .act        (act),
        .addr       (addr),
        .beat_wdata (beat_wdata),
        .beat_be    (beat_be)
    );

    sram_pin_drive #(.AW(AW), .DW(DW)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .cnt        (cnt),
        .oe_dly     (act.oe_dly),
        .we_dly     (act.we_dly),
        .wr_len     (act.wr_len),
        .cs_high    (act.cs_high),
        .lanes_rd   (act.lanes_rd),
        .addr       (addr),
        .beat_wdata (beat_wdata),
        .beat_be    (beat_be),
        .mem_cs     (mem_cs),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_bls_n  (mem_bls_n),
        .mem_addr   (mem_addr),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe)
    );

    assign mem_dq = dq_oe ? dq_out : {DW{1'bz}};

    // R12: ready is withheld while the data bus is in use
    p_ready_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !req_ready);

endmodule

// File: tb/sram_timing_ctrl_tb.sv
module sram_timing_ctrl_tb;

    localparam int AW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [4:0]  cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_wide = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        mem_cs, mem_oe_n, mem_we_n;
    logic [1:0]  mem_bls_n;
    logic [AW-1:0] mem_addr;
    wire  [15:0] mem_dq;

    always #2 clk = ~clk;

    sram_timing_ctrl #(.AW(AW), .DW(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_wide(req_wide),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_bls_n(mem_bls_n),
        .mem_addr(mem_addr), .mem_dq(mem_dq)
    );

    // memory model
    logic [15:0] model [0:255];

    function automatic logic [15:0] init_val(input int i);
        return 16'(i * 16'h0101) ^ 16'h5A3C;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) model[i] <= init_val(i);
        end else if (!mem_we_n) begin
            if (!mem_bls_n[0]) model[mem_addr][7:0]  <= mem_dq[7:0];
            if (!mem_bls_n[1]) model[mem_addr][15:8] <= mem_dq[15:8];
        end
    end

    assign mem_dq = (!mem_oe_n && mem_we_n) ? model[mem_addr] : 16'hzzzz;

    // pin monitor
    int   nb = 0, gapc = 0, k;
    int   blen [4], boe [4], bwef [4], bwel [4], bgap [4];
    logic [1:0] brd [4], bwb [4];
    logic cs_pol_exp = 1'b0, pol_stage = 1'b0, prev_cs = 1'b0, cs_now;

    always @(negedge clk) begin
        if (rst_n) begin
            cs_now = (mem_cs == cs_pol_exp);
            if (cs_now) begin
                if (!prev_cs) begin
                    if (nb < 4) begin
                        bgap[nb] = gapc; blen[nb] = 0; boe[nb] = -1;
                        bwef[nb] = -1; bwel[nb] = 0; brd[nb] = 2'b11; bwb[nb] = 2'b11;
                    end
                    nb++;
                end
                k = nb - 1;
                if (k < 4) begin
                    if (!mem_oe_n && boe[k] < 0) boe[k] = blen[k];
                    if (!mem_oe_n) brd[k] = mem_bls_n;
                    if (!mem_we_n) begin
                        if (bwef[k] < 0) begin bwef[k] = blen[k]; bwb[k] = mem_bls_n; end
                        bwel[k]++;
                    end
                    blen[k]++;
                end
                gapc = 0;
            end else begin
                gapc++;
            end
            prev_cs = cs_now;
        end
    end

    int total = 0, bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint actv, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, actv, expv);
        end
    endtask

    task automatic cfg_write(input int sel, input int val);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 3'(sel); cfg_wdata = 5'(val);
        if (sel == 6) pol_stage = val[0];
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic start_req(input bit w, input bit wide, input int a, input logic [31:0] wd, input logic [3:0] be);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        nb = 0;
        req_valid = 1'b1; req_write = w; req_wide = wide;
        req_addr = AW'(a); req_wdata = wd; req_be = be;
        @(posedge clk);
        cs_pol_exp = pol_stage;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_rsp(output logic [31:0] rd);
        while (!rsp_valid) @(negedge clk);
        rd = rsp_rdata;
    endtask

    task automatic do_req(input bit w, input bit wide, input int a, input logic [31:0] wd,
                          input logic [3:0] be, output logic [31:0] rd);
        start_req(w, wide, a, wd, be);
        wait_rsp(rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R12 actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [15:0] ev;
        int a, exp_len;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_cs === 1'b1 && mem_oe_n === 1'b1 && mem_we_n === 1'b1, "R1 strobes", {mem_cs, mem_oe_n, mem_we_n}, 3'b111);
        chk(mem_bls_n === 2'b11, "R1 lanes", mem_bls_n, 2'b11);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_dq === 16'hzzzz && req_ready === 1'b1, "R1 bus/ready", {req_ready, mem_dq}, 1);

        // R2 read sweep
        for (int rdl = 0; rdl < 6; rdl++) begin
            for (int oe = 0; oe <= rdl; oe++) begin
                cfg_write(1, rdl); cfg_write(0, oe);
                a = rdl * 8 + oe;
                do_req(1'b0, 1'b0, a, 32'h0, 4'h0, rd);
                chk(nb == 1 && blen[0] == rdl + 1, "R2 cs length", blen[0], rdl + 1);
                chk(boe[0] == oe, "R2 oe delay", boe[0], oe);
                chk(rd == {16'h0, init_val(a)}, "R2 R12 read data", rd, {16'h0, init_val(a)});
            end
        end

        // R3 write sweep
        for (int wr = 0; wr < 5; wr++) begin
            for (int we = 0; we < 4; we++) begin
                cfg_write(4, wr); cfg_write(3, we);
                a = 100 + wr * 4 + we;
                ev = 16'(16'hC000 + a);
                do_req(1'b1, 1'b0, a, {16'h0, ev}, 4'h3, rd);
                exp_len = (wr > we) ? wr - we : 0;
                chk(blen[0] == wr + 2, "R3 cs length", blen[0], wr + 2);
                chk(bwel[0] == exp_len, "R3 we length", bwel[0], exp_len);
                chk(bwef[0] == ((exp_len > 0) ? we + 1 : -1), "R3 we start", bwef[0], we + 1);
                chk(model[a] == ((exp_len > 0) ? ev : init_val(a)), "R3 stored", model[a], ev);
            end
        end

        // R5 byte enables
        cfg_write(4, 3); cfg_write(3, 0);
        for (int be = 0; be < 4; be++) begin
            a = 200 + be;
            do_req(1'b1, 1'b0, a, 32'h0000_1234, 4'(be), rd);
            ev = init_val(a);
            if (be[0]) ev[7:0] = 8'h34;
            if (be[1]) ev[15:8] = 8'h12;
            chk(model[a] == ev, "R5 lane merge", model[a], ev);
            chk(bwb[0] == ~2'(be) || be == 0, "R5 lane strobe", bwb[0], ~2'(be));
        end

        // R6 lanes on read
        cfg_write(1, 2); cfg_write(0, 1);
        cfg_write(6, 0);
        do_req(1'b0, 1'b0, 5, 32'h0, 4'h0, rd);
        chk(brd[0] == 2'b11, "R6 lanes idle on read", brd[0], 2'b11);
        cfg_write(6, 2);
        do_req(1'b0, 1'b0, 5, 32'h0, 4'h0, rd);
        chk(brd[0] == 2'b00, "R6 lanes on read", brd[0], 2'b00);
        cfg_write(6, 0);

        // R7 R8 wide with turnaround
        for (int t = 0; t < 4; t++) begin
            cfg_write(5, t);
            a = 40 + 2 * t;
            do_req(1'b1, 1'b1, a + 1, 32'hA1B2_C3D4 + t, 4'hF, rd);
            chk(nb == 2 && bgap[1] == t + 1, "R8 write beat gap", bgap[1], t + 1);
            chk(model[a] == 16'(16'hC3D4 + t) && model[a + 1] == 16'hA1B2, "R7 write halves",
                {model[a + 1], model[a]}, 32'hA1B2_C3D4 + t);
            do_req(1'b0, 1'b1, a, 32'h0, 4'h0, rd);
            chk(nb == 2 && bgap[1] == t + 1, "R8 read beat gap", bgap[1], t + 1);
            chk(bgap[0] >= t + 1, "R8 request gap", bgap[0], t + 1);
            chk(rd == 32'hA1B2_C3D4 + t, "R7 read assembly", rd, 32'hA1B2_C3D4 + t);
        end

        // R9 page mode
        cfg_write(6, 4); cfg_write(1, 2); cfg_write(0, 0);
        for (int pg = 0; pg < 4; pg++) begin
            cfg_write(2, pg);
            do_req(1'b0, 1'b1, 60, 32'h0, 4'h0, rd);
            chk(nb == 1 && blen[0] == 3 + pg + 1, "R9 page length", blen[0], 4 + pg);
            chk(rd == {init_val(61), init_val(60)}, "R9 page data", rd, {init_val(61), init_val(60)});
        end
        do_req(1'b1, 1'b1, 70, 32'h1111_2222, 4'hF, rd);
        chk(nb == 2, "R9 no page on write", nb, 2);
        cfg_write(6, 0);

        // R10 polarity
        cfg_write(6, 1);
        do_req(1'b0, 1'b0, 7, 32'h0, 4'h0, rd);
        chk(nb == 1 && blen[0] == 3, "R10 active high beat", blen[0], 3);
        repeat (8) @(negedge clk);
        chk(mem_cs == 1'b0, "R10 idle level high polarity", mem_cs, 0);
        cfg_write(6, 0);
        do_req(1'b0, 1'b0, 7, 32'h0, 4'h0, rd);
        repeat (8) @(negedge clk);
        chk(mem_cs == 1'b1, "R10 idle level low polarity", mem_cs, 1);

        // R11 config write during an access
        cfg_write(1, 5);
        start_req(1'b0, 1'b0, 9, 32'h0, 4'h0);
        chk(req_ready == 1'b0, "R12 busy ready", req_ready, 0);
        cfg_write(1, 0);
        wait_rsp(rd);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R12 single pulse", rsp_valid, 0);
        chk(blen[0] == 6, "R11 running access", blen[0], 6);
        do_req(1'b0, 1'b0, 9, 32'h0, 4'h0, rd);
        chk(blen[0] == 1, "R11 next access", blen[0], 1);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule